// File: doc/BRIEF.md
# Conversion Result Holding Registers with Read Interlock

This block sits between a successive-approximation converter core and the bus. Every time the core signals a finished conversion, the block decides whether to keep the value. It keeps it in a 12-bit result store that software reads as two bytes, a high byte and a low byte. The core can run at 12-bit, 10-bit or 8-bit resolution. A result is always right aligned, and any bit above the active width reads as zero.

In the two wider modes, a high-byte read locks the store until the matching low-byte read. The two bytes software collects therefore always belong to the same conversion. A conversion that finishes while the store is locked is thrown away. An optional automatic compare stores a result only when it is below, or at least equal to, a programmable 12-bit threshold. The threshold is held in two writable compare bytes. A change of resolution wipes the store and releases any lock.

Top module: `adcResultRegs`

## Requirements
- R1: After reset, the result low byte (rdSel=0), the result high byte (rdSel=1), the compare low byte (rdSel=2) and the compare high byte (rdSel=3) all read 0x00.
- R2: A stored result is the conversion value masked to the active width: modeSel=0 selects 8 bits, 1 selects 10 bits, and 2 or 3 select 12 bits. The low byte reads result bits 7:0. The high byte reads result bits 11:8 in its bits 3:0, with zeros above them, so it reads only bits 9:8 in 10-bit mode and 0x00 in 8-bit mode.
- R3: With cmpEn=1, a finished conversion whose masked value fails the selected compare condition leaves the stored result unchanged.
- R4: In 10-bit and 12-bit mode, a high-byte read sets a lock from the next cycle on. The lock holds until a low-byte read releases it.
- R5: A conversion that finishes while the lock is set is discarded. It does not appear after the lock is released.
- R6: In 8-bit mode a high-byte read sets no lock, and later conversions are stored.
- R7: A change of the mode selection, after normalization, clears the stored result to zero and releases the lock. A conversion finishing in that same cycle is discarded.
- R8: A compare-byte write with cmpWrHi=1 loads wrData[3:0] into the compare high byte, which reads with bits 7:4 zero. A write with cmpWrHi=0 loads all eight bits of wrData into the compare low byte.
- R9: The compare operands are the conversion value and the 12-bit compare value, both masked to the active width. cmpGe=1 passes when the result is greater than or equal to the compare value. cmpGe=0 passes when the result is below it.
- R10: In 10-bit or 12-bit mode, a low-byte read that coincides with a finished conversion returns the old low byte, releases the lock, and discards the new conversion.
- R11: In 10-bit or 12-bit mode, a high-byte read while unlocked that coincides with a finished conversion returns the old high byte and discards the new conversion, so the locked pair stays coherent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Resolution: 0 = 8-bit, 1 = 10-bit, 2 or 3 = 12-bit |
| convDone | input | 1 | One-cycle strobe: conversion finished |
| convData | input | 12 | Raw conversion value, right aligned |
| cmpEn | input | 1 | Enable automatic compare gating |
| cmpGe | input | 1 | Compare condition: 1 = greater or equal, 0 = less than |
| cmpWrEn | input | 1 | Write strobe for a compare byte |
| cmpWrHi | input | 1 | Compare byte select: 1 = high, 0 = low |
| wrData | input | 8 | Compare byte write data |
| rdEn | input | 1 | Read strobe, used for the interlock side effects |
| rdSel | input | 2 | Read select: 0 result low, 1 result high, 2 compare low, 3 compare high |
| rdData | output | 8 | Read data for the selected register (combinational) |

## Verification
The hardest situations to reach from the ports are the ones where a conversion strobe lands in the same clock as a byte read. Both the interlock and the capture decision then change on one edge. Here the bench must tell an old value from a new one. The stimulus first parks a known value and locks it. It then raises convDone together with rdEn for a single cycle, carrying a value whose bytes all differ from the parked ones. Follow-up reads show which value survived and whether the lock is still set.

// File: rtl/adcRrPkg.sv
package adcRrPkg;

  typedef enum logic [1:0] {
    MODE8  = 2'd0,
    MODE10 = 2'd1,
    MODE12 = 2'd2
  } rrMode_t;

  typedef enum logic [1:0] {
    SEL_RES_LO = 2'd0,
    SEL_RES_HI = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } rrSel_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } rrStrobe_t;

endpackage

// File: rtl/adcRrCtrl.sv
module adcRrCtrl
  import adcRrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       convDone,
  input  logic       cmpEn,
  input  logic       cmpPass,
  input  logic       rdEn,
  input  logic [1:0] rdSel,
  output rrStrobe_t  strobe,
  output rrMode_t    modeQ,
  output logic       lockQ
);

  rrMode_t modeNew;
  logic    modeChg;
  logic    loRead;
  logic    hiRead;
  logic    wideMode;
  logic    blocked;
  logic    cmpOk;

  always_comb begin
    unique case (modeSel)
      2'd0:    modeNew = MODE8;
      2'd1:    modeNew = MODE10;
      default: modeNew = MODE12;
    endcase
  end

  assign modeChg  = (modeNew != modeQ);
  assign wideMode = (modeQ != MODE8);
  assign loRead   = rdEn && (rdSel == SEL_RES_LO);
  assign hiRead   = rdEn && (rdSel == SEL_RES_HI) && wideMode;
  // an unlocked pair read in the wide modes also keeps the store quiet that cycle
  assign blocked  = lockQ || (wideMode && (hiRead || loRead));
  assign cmpOk    = !cmpEn || cmpPass;

  always_comb begin
    strobe.clear   = modeChg;
    strobe.capture = convDone && !modeChg && !blocked && cmpOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE8;
      lockQ <= 1'b0;
    end else begin
      modeQ <= modeNew;
      if (modeChg || loRead) begin
        lockQ <= 1'b0;
      end else if (hiRead) begin
        lockQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adcRrDatapath.sv
module adcRrDatapath
  import adcRrPkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rrStrobe_t         strobe,
  input  rrMode_t           modeQ,
  input  logic [RES_W-1:0]  convData,
  input  logic              cmpGe,
  input  logic              cmpWrEn,
  input  logic              cmpWrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic              cmpPass,
  output logic [RES_W-1:0]  resultQ,
  output logic [RES_W-BYTE_W-1:0] cmpHiQ,
  output logic [BYTE_W-1:0] cmpLoQ
);

  localparam int HI_W  = RES_W - BYTE_W;
  localparam int MID_W = RES_W - 2;

  logic [RES_W-1:0] widthMask;
  logic [RES_W-1:0] convMasked;
  logic [RES_W-1:0] cmpMasked;

  always_comb begin
    unique case (modeQ)
      MODE8:   widthMask = RES_W'((1 << BYTE_W) - 1);
      MODE10:  widthMask = RES_W'((1 << MID_W) - 1);
      default: widthMask = '1;
    endcase
  end

  assign convMasked = convData & widthMask;
  assign cmpMasked  = {cmpHiQ, cmpLoQ} & widthMask;
  assign cmpPass    = cmpGe ? (convMasked >= cmpMasked) : (convMasked < cmpMasked);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.clear) begin
      resultQ <= '0;
    end else if (strobe.capture) begin
      resultQ <= convMasked;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpHiQ <= '0;
      cmpLoQ <= '0;
    end else if (cmpWrEn) begin
      if (cmpWrHi) begin
        cmpHiQ <= wrData[HI_W-1:0];
      end else begin
        cmpLoQ <= wrData;
      end
    end
  end

endmodule

// File: rtl/adcResultRegs.sv
module adcResultRegs
  import adcRrPkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic              cmpEn,
  input  logic              cmpGe,
  input  logic              cmpWrEn,
  input  logic              cmpWrHi,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdSel,
  output logic [BYTE_W-1:0] rdData
);

  localparam int HI_W  = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  rrStrobe_t         strobe;
  rrMode_t           modeQ;
  logic              lockQ;
  logic              cmpPass;
  logic [RES_W-1:0]  resultQ;
  logic [HI_W-1:0]   cmpHiQ;
  logic [BYTE_W-1:0] cmpLoQ;

  adcRrCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .convDone (convDone),
    .cmpEn    (cmpEn),
    .cmpPass  (cmpPass),
    .rdEn     (rdEn),
    .rdSel    (rdSel),
    .strobe   (strobe),
    .modeQ    (modeQ),
    .lockQ    (lockQ)
  );

  adcRrDatapath #(.RES_W(RES_W), .BYTE_W(BYTE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modeQ    (modeQ),
    .convData (convData),
    .cmpGe    (cmpGe),
    .cmpWrEn  (cmpWrEn),
    .cmpWrHi  (cmpWrHi),
    .wrData   (wrData),
    .cmpPass  (cmpPass),
    .resultQ  (resultQ),
    .cmpHiQ   (cmpHiQ),
    .cmpLoQ   (cmpLoQ)
  );

  always_comb begin
    unique case (rdSel)
      SEL_RES_LO: rdData = resultQ[BYTE_W-1:0];
      SEL_RES_HI: rdData = {{PAD_W{1'b0}}, resultQ[RES_W-1:BYTE_W]};
      SEL_CMP_LO: rdData = cmpLoQ;
      default:    rdData = {{PAD_W{1'b0}}, cmpHiQ};
    endcase
  end

endmodule

// File: rtl/adcRrChecker.sv
module adcRrChecker #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              convDone,
  input logic              cmpEn,
  input logic              rdEn,
  input logic [1:0]        rdSel,
  input logic [BYTE_W-1:0] rdData,
  input logic [1:0]        modeQ,
  input logic              lockQ,
  input logic              modeChg,
  input logic              cmpPass,
  input logic [RES_W-1:0]  resultQ
);

  // R4: a locked store keeps its value
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    lockQ && !modeChg |=> $stable(resultQ));

  // R4: a high-byte read in a wide mode sets the lock
  a_r4_lock_set: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdSel == 2'd1 && modeQ != 2'd0 && !modeChg |=> lockQ);

  // R3: a failed compare leaves the store unchanged
  a_r3_cmp_gate: assert property (@(posedge clk) disable iff (!rstN)
    convDone && cmpEn && !cmpPass && !modeChg |=> $stable(resultQ));

  // R6: no lock in 8-bit mode
  a_r6_no_lock_8bit: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == 2'd0 |-> !lockQ);

  // R7: mode change wipes the store and the lock
  a_r7_mode_clear: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (resultQ == '0) && !lockQ);

  // R10: coinciding low read and conversion in a wide mode
  a_r10_lo_read_drop: assert property (@(posedge clk) disable iff (!rstN)
    convDone && rdEn && rdSel == 2'd0 && modeQ != 2'd0 && !modeChg
      |=> $stable(resultQ) && !lockQ);

  // R2: padding above the active width
  a_r2_pad_10: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == 2'd1 |-> resultQ[RES_W-1:RES_W-2] == '0);

  a_r2_pad_8: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == 2'd0 |-> resultQ[RES_W-1:BYTE_W] == '0);

  // R2: the high result byte never shows bits above bit 3
  a_r2_hi_byte: assert property (@(posedge clk) disable iff (!rstN)
    rdSel == 2'd1 |-> rdData[BYTE_W-1:RES_W-BYTE_W] == '0);

endmodule

bind adcResultRegs adcRrChecker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .convDone (convDone),
  .cmpEn    (cmpEn),
  .rdEn     (rdEn),
  .rdSel    (rdSel),
  .rdData   (rdData),
  .modeQ    (modeQ),
  .lockQ    (lockQ),
  .modeChg  (strobe.clear),
  .cmpPass  (cmpPass),
  .resultQ  (resultQ)
);

// File: tb/adcResultRegs_test.sv
module adcResultRegs_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd2;
  logic        convDone = 1'b0;
  logic [11:0] convData = '0;
  logic        cmpEn = 1'b0;
  logic        cmpGe = 1'b0;
  logic        cmpWrEn = 1'b0;
  logic        cmpWrHi = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdSel = 2'd0;
  logic [7:0]  rdData;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  adcResultRegs uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .convDone(convDone),
    .convData(convData), .cmpEn(cmpEn), .cmpGe(cmpGe), .cmpWrEn(cmpWrEn),
    .cmpWrHi(cmpWrHi), .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // one read cycle; optional coinciding conversion
  task automatic rd(input logic [1:0] sel, input logic withConv,
                    input logic [11:0] val, output logic [7:0] got);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    convDone = withConv; convData = val;
    #1 got = rdData;
    @(negedge clk);
    rdEn = 1'b0; convDone = 1'b0;
  endtask

  task automatic conv(input logic [11:0] val);
    @(negedge clk);
    convDone = 1'b1; convData = val;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    @(negedge clk);
  endtask

  task automatic wrCmp(input logic hi, input logic [7:0] d);
    @(negedge clk);
    cmpWrEn = 1'b1; cmpWrHi = hi; wrData = d;
    @(negedge clk);
    cmpWrEn = 1'b0;
  endtask

  // high first then low, leaving the store unlocked
  task automatic pair(input string tag, input logic [7:0] expHi, input logic [7:0] expLo);
    logic [7:0] g;
    rd(2'd1, 1'b0, '0, g); check({tag, " hi"}, g, expHi);
    rd(2'd0, 1'b0, '0, g); check({tag, " lo"}, g, expLo);
  endtask

  task automatic tReset();
    logic [7:0] g;
    pair("R1 reset", 8'h00, 8'h00);
    rd(2'd2, 1'b0, '0, g); check("R1 cmp lo", g, 8'h00);
    rd(2'd3, 1'b0, '0, g); check("R1 cmp hi", g, 8'h00);
  endtask

  task automatic tPadding();
    setMode(2'd2); conv(12'hABC); pair("R2 12bit", 8'h0A, 8'hBC);
    setMode(2'd1); conv(12'hFFF); pair("R2 10bit", 8'h03, 8'hFF);
    setMode(2'd0); conv(12'hFA5); pair("R2 8bit", 8'h00, 8'hA5);
    setMode(2'd3); conv(12'h9D4); pair("R2 mode3", 8'h09, 8'hD4);
  endtask

  task automatic tCmpRegs();
    logic [7:0] g;
    wrCmp(1'b1, 8'hFF); rd(2'd3, 1'b0, '0, g); check("R8 cmp hi", g, 8'h0F);
    wrCmp(1'b0, 8'hA5); rd(2'd2, 1'b0, '0, g); check("R8 cmp lo", g, 8'hA5);
  endtask

  task automatic tLock();
    logic [7:0] g;
    setMode(2'd2);
    conv(12'h123);
    rd(2'd1, 1'b0, '0, g); check("R4 hi", g, 8'h01);
    conv(12'h456);
    rd(2'd0, 1'b0, '0, g); check("R5 dropped lo", g, 8'h23);
    conv(12'h789); pair("R4 released", 8'h07, 8'h89);
  endtask

  task automatic tSameCycleLo();
    logic [7:0] g;
    conv(12'hABC);
    rd(2'd1, 1'b0, '0, g); check("R10 hi", g, 8'h0A);
    rd(2'd0, 1'b1, 12'hDEF, g); check("R10 old lo", g, 8'hBC);
    pair("R10 new dropped", 8'h0A, 8'hBC);
    conv(12'h321); pair("R10 unlocked", 8'h03, 8'h21);
  endtask

  task automatic tSameCycleHi();
    logic [7:0] g;
    rd(2'd1, 1'b1, 12'h654, g); check("R11 old hi", g, 8'h03);
    rd(2'd0, 1'b0, '0, g); check("R11 lo kept", g, 8'h21);
  endtask

  task automatic tNoLock8();
    logic [7:0] g;
    setMode(2'd0);
    conv(12'h0C3);
    rd(2'd1, 1'b0, '0, g); check("R6 hi", g, 8'h00);
    conv(12'h05A);
    rd(2'd0, 1'b0, '0, g); check("R6 lo", g, 8'h5A);
  endtask

  task automatic tModeChange();
    logic [7:0] g;
    setMode(2'd2);
    conv(12'hFED);
    rd(2'd1, 1'b0, '0, g); check("R7 hi before", g, 8'h0F);
    setMode(2'd1);
    rd(2'd0, 1'b0, '0, g); check("R7 cleared lo", g, 8'h00);
    rd(2'd1, 1'b0, '0, g); check("R7 cleared hi", g, 8'h00);
    rd(2'd0, 1'b0, '0, g);
    conv(12'h3AA); pair("R7 after", 8'h03, 8'hAA);
  endtask

  task automatic tCompare();
    setMode(2'd2);
    wrCmp(1'b1, 8'h08); wrCmp(1'b0, 8'h00);
    conv(12'h111);
    @(negedge clk); cmpEn = 1'b1; cmpGe = 1'b1;
    conv(12'h7FF); pair("R3 ge fail", 8'h01, 8'h11);
    conv(12'h800); pair("R9 ge pass", 8'h08, 8'h00);
    @(negedge clk); cmpGe = 1'b0;
    conv(12'h900); pair("R3 lt fail", 8'h08, 8'h00);
    conv(12'h1AB); pair("R9 lt pass", 8'h01, 8'hAB);
    setMode(2'd1);
    wrCmp(1'b1, 8'h02);
    @(negedge clk); cmpGe = 1'b1;
    conv(12'hC05); pair("R9 masked fail", 8'h00, 8'h00);
    conv(12'h2F0); pair("R9 masked pass", 8'h02, 8'hF0);
    @(negedge clk); cmpEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tPadding();
    tCmpRegs();
    tLock();
    tSameCycleLo();
    tSameCycleHi();
    tNoLock8();
    tModeChange();
    tCompare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule